// File: doc/BRIEF.md
# Frequency Synthesizer Divider and Lock Monitor

This block is the digital heart of a frequency-synthesizer loop. A programmable feedback divider counts VCO edges, and a reference divider counts edges of a 75 kHz crystal clock. A phase-frequency comparator then turns the two divided streams into pump-up and pump-down requests for an external charge pump. Both edge streams reach the block as one-cycle enable pulses that are already synchronized to the system clock.

The feedback divider has three modes. The first doubles a full 16-bit ratio. The second uses the full 16-bit ratio as it is. The third, for the low band, uses only the top twelve bits of the word. A 4-bit reference code picks the reference ratio. Two of its codes halt the whole loop and put the pump in high impedance, and one of those two also stops the crystal.

A lock monitor has three modes: it can be switched off, it can pass the raw phase error, or it can judge the width of each error against a window and stretch any unlock it finds. A force input holds the pump sinking so that a stalled VCO can be recovered.

Top module: `synth_pll_core`

## Requirements
- R1: With `dbl_mode`=1, `pump_dn` is raised after exactly 2·N `vco_tick` pulses, where N is the full 16-bit `div_word`.
- R2: With `dbl_mode`=0 and `hi_band`=1, the feedback ratio is N, where N is the full 16-bit `div_word`.
- R3: With `dbl_mode`=0 and `hi_band`=0, N is `div_word[15:4]`, `div_word[3:0]` has no effect, and the ratio is N.
- R4: N below 272 in the R1 and R2 modes, or below 4 in the R3 mode, is treated as that minimum.
- R5: The reference ratio in `xtal_tick` pulses follows `ref_sel`: 0 to 3 give 3; 4 gives 6; 5 gives 12; 6 and 7 give 24; 8 to 10 give 15; 11 gives 75; 12 gives 25; 13 gives 5.
- R6: A change to the divide word or the mode takes effect only at the next terminal count, so the period in progress keeps its length. The first period after reset, or after a halt ends, is a full period.
- R7: A reference pulse raises `pump_up` and a feedback pulse raises `pump_dn`. Each stays high until the other pulse arrives, and then both clear. When both pulses arrive in the same cycle, neither output rises.
- R8: `ref_sel`=14 and `ref_sel`=15 halt both dividers, set `pump_hiz`=1 and hold `pump_up` and `pump_dn` at 0. Only code 14 also sets `xtal_stop`=1.
- R9: With `force_low`=1, `pump_dn` is held at 1 and `pump_up` at 0. A halt from R8 overrides this. With `force_low`=0, normal operation resumes.
- R10: With `ulk_mode`=0b00, `lock_ok` stays 1.
- R11: With `ulk_mode`=0b01, `lock_ok` is the inverse of the phase error (`pump_up` or `pump_dn`), one cycle later.
- R12: With `ulk_mode`=0b1x, an error lasting more than ERR_LIMIT consecutive cycles drives `lock_ok` to 0. It stays 0 for HOLD_LEN cycles after the last over-limit cycle. Shorter errors leave it at 1.
- R13: After reset, `pump_up`, `pump_dn`, `pump_hiz` and `xtal_stop` are 0 and `lock_ok` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| vco_tick | input | 1 | One-cycle pulse per VCO edge |
| xtal_tick | input | 1 | One-cycle pulse per crystal edge |
| div_word | input | 16 | Feedback divide word |
| dbl_mode | input | 1 | Doubled wide mode select |
| hi_band | input | 1 | Wide (1) or narrow (0) ratio when not doubled |
| ref_sel | input | 4 | Reference ratio code |
| ulk_mode | input | 2 | Lock monitor mode |
| force_low | input | 1 | Hold the pump sinking |
| pump_up | output | 1 | Pump-up request |
| pump_dn | output | 1 | Pump-down request |
| pump_hiz | output | 1 | Pump high-impedance enable |
| lock_ok | output | 1 | 1 = locked or monitor off, 0 = unlocked |
| xtal_stop | output | 1 | Crystal oscillator stop request |

## Verification
The case of interest is a reference terminal count and a feedback terminal count landing in the same cycle. To provoke it, both ratios are set to five and the two tick inputs are pulsed together. The run is judged by both pump outputs staying low through the coincidence. A later burst of only reference ticks must then raise `pump_up` after a full reference period, which shows that both dividers reloaded correctly.

// File: rtl/synth_pll_pkg.sv
package synth_pll_pkg;

  localparam int REF_RW = 7;

  typedef enum logic [1:0] {
    DET_OFF  = 2'b00,
    DET_RAW  = 2'b01,
    DET_WIN  = 2'b10,
    DET_WIN2 = 2'b11
  } det_mode_e;

  // Crystal ticks per reference period; halt codes return 1 (unused).
  function automatic logic [REF_RW-1:0] ref_ratio(input logic [3:0] code);
    case (code)
      4'd0, 4'd1, 4'd2, 4'd3: ref_ratio = REF_RW'(3);
      4'd4:                   ref_ratio = REF_RW'(6);
      4'd5:                   ref_ratio = REF_RW'(12);
      4'd6, 4'd7:             ref_ratio = REF_RW'(24);
      4'd8, 4'd9, 4'd10:      ref_ratio = REF_RW'(15);
      4'd11:                  ref_ratio = REF_RW'(75);
      4'd12:                  ref_ratio = REF_RW'(25);
      4'd13:                  ref_ratio = REF_RW'(5);
      default:                ref_ratio = REF_RW'(1);
    endcase
  endfunction

  function automatic logic ref_halt(input logic [3:0] code);
    return code[3] & code[2] & code[1];
  endfunction

endpackage

// File: rtl/synth_prog_div.sv
module synth_prog_div #(
  parameter int DW         = 16,
  parameter int MIN_WIDE   = 272,
  parameter int MIN_NARROW = 4,
  parameter int NARROW_LSB = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          halt,
  input  logic          tick,
  input  logic [DW-1:0] word,
  input  logic          dbl,
  input  logic          hi,
  output logic          pulse_o
);
  localparam int RW = DW + 1;
  localparam int NW = DW - NARROW_LSB;

  logic [DW-1:0] n_wide;
  logic [NW-1:0] n_narrow;
  logic [RW-1:0] ratio, cnt;
  logic          load_q;

  always_comb begin
    n_wide   = (word < DW'(MIN_WIDE)) ? DW'(MIN_WIDE) : word;
    n_narrow = (word[DW-1:NARROW_LSB] < NW'(MIN_NARROW)) ?
               NW'(MIN_NARROW) : word[DW-1:NARROW_LSB];
    if (dbl)     ratio = {n_wide, 1'b0};
    else if (hi) ratio = {1'b0, n_wide};
    else         ratio = RW'(n_narrow);
  end

  // Counter reloads only at terminal count, after reset, or after a halt.
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      load_q  <= 1'b1;
      pulse_o <= 1'b0;
    end else begin
      pulse_o <= 1'b0;
      load_q  <= halt;
      if (halt || load_q) begin
        cnt <= ratio - RW'(1);
      end else if (tick) begin
        if (cnt == '0) begin
          cnt     <= ratio - RW'(1);
          pulse_o <= 1'b1;
        end else begin
          cnt <= cnt - RW'(1);
        end
      end
    end
  end

  p_no_back2back_r6: assert property (@(posedge clk) disable iff (rst)
    pulse_o |=> !pulse_o);
  p_halt_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    halt |=> !pulse_o);

endmodule

// File: rtl/synth_ref_div.sv
module synth_ref_div
  import synth_pll_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [3:0] code,
  input  logic       tick,
  output logic       halt_o,
  output logic       xstop_o,
  output logic       pulse_o
);
  logic [REF_RW-1:0] ratio, cnt;
  logic              load_q;

  assign halt_o = ref_halt(code);
  assign ratio  = ref_ratio(code);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      load_q  <= 1'b1;
      pulse_o <= 1'b0;
      xstop_o <= 1'b0;
    end else begin
      pulse_o <= 1'b0;
      load_q  <= halt_o;
      xstop_o <= (code == 4'b1110);
      if (halt_o || load_q) begin
        cnt <= ratio - REF_RW'(1);
      end else if (tick) begin
        if (cnt == '0) begin
          cnt     <= ratio - REF_RW'(1);
          pulse_o <= 1'b1;
        end else begin
          cnt <= cnt - REF_RW'(1);
        end
      end
    end
  end

  p_ref_halt_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    halt_o |=> !pulse_o);

endmodule

// File: rtl/synth_phase_cmp.sv
module synth_phase_cmp (
  input  logic clk,
  input  logic rst,
  input  logic halt,
  input  logic force_low,
  input  logic ref_p,
  input  logic div_p,
  output logic up_o,
  output logic dn_o,
  output logic hiz_o,
  output logic err_o
);
  logic st_up, st_dn, nu, nd, clr;

  always_comb begin
    nu  = st_up | ref_p;
    nd  = st_dn | div_p;
    clr = nu & nd;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_up <= 1'b0; st_dn <= 1'b0;
      up_o  <= 1'b0; dn_o  <= 1'b0; hiz_o <= 1'b0;
    end else if (halt) begin
      st_up <= 1'b0; st_dn <= 1'b0;
      up_o  <= 1'b0; dn_o  <= 1'b0; hiz_o <= 1'b1;
    end else begin
      st_up <= nu & ~clr;
      st_dn <= nd & ~clr;
      up_o  <= nu & ~clr & ~force_low;
      dn_o  <= force_low | (nd & ~clr);
      hiz_o <= 1'b0;
    end
  end

  assign err_o = st_up | st_dn;

  p_up_cause_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(up_o) |-> ($past(ref_p) || $past(force_low, 2)));
  p_halt_hiz_r8: assert property (@(posedge clk) disable iff (rst)
    halt |=> (hiz_o && !up_o && !dn_o));

endmodule

// File: rtl/synth_lock_mon.sv
module synth_lock_mon
  import synth_pll_pkg::*;
#(
  parameter int ERR_LIMIT = 1334,
  parameter int HOLD_LEN  = 300000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] mode_i,
  input  logic       err_i,
  output logic       lock_o
);
  localparam int RCW = $clog2(ERR_LIMIT + 1);
  localparam int HCW = $clog2(HOLD_LEN + 1);

  det_mode_e      mode;
  logic [RCW-1:0] run;
  logic [HCW-1:0] hold;
  logic           over;

  assign mode = det_mode_e'(mode_i);
  assign over = mode_i[1] && err_i && (run >= RCW'(ERR_LIMIT));

  always_ff @(posedge clk) begin
    if (rst) begin
      run    <= '0;
      hold   <= '0;
      lock_o <= 1'b1;
    end else begin
      case (mode)
        DET_OFF: begin
          run <= '0; hold <= '0; lock_o <= 1'b1;
        end
        DET_RAW: begin
          run <= '0; hold <= '0; lock_o <= ~err_i;
        end
        default: begin
          if (!err_i)                       run <= '0;
          else if (run != RCW'(ERR_LIMIT))  run <= run + RCW'(1);
          if (over)              hold <= HCW'(HOLD_LEN);
          else if (hold != '0)   hold <= hold - HCW'(1);
          lock_o <= ~(over || (hold != '0));
        end
      endcase
    end
  end

  p_off_locked_r10: assert property (@(posedge clk) disable iff (rst)
    (mode_i == 2'b00) |=> lock_o);
  p_raw_follow_r11: assert property (@(posedge clk) disable iff (rst)
    (mode_i == 2'b01) |=> (lock_o == !$past(err_i)));
  p_fall_cause_r12: assert property (@(posedge clk) disable iff (rst)
    ($fell(lock_o) && $past(mode_i[1])) |-> $past(err_i));

endmodule

// File: rtl/synth_pll_core.sv
module synth_pll_core #(
  parameter int DW         = 16,
  parameter int MIN_WIDE   = 272,
  parameter int MIN_NARROW = 4,
  parameter int NARROW_LSB = 4,
  parameter int ERR_LIMIT  = 1334,
  parameter int HOLD_LEN   = 300000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          vco_tick,
  input  logic          xtal_tick,
  input  logic [DW-1:0] div_word,
  input  logic          dbl_mode,
  input  logic          hi_band,
  input  logic [3:0]    ref_sel,
  input  logic [1:0]    ulk_mode,
  input  logic          force_low,
  output logic          pump_up,
  output logic          pump_dn,
  output logic          pump_hiz,
  output logic          lock_ok,
  output logic          xtal_stop
);
  logic halt, ref_p, div_p, err;

  synth_ref_div u_ref (
    .clk(clk), .rst(rst), .code(ref_sel), .tick(xtal_tick),
    .halt_o(halt), .xstop_o(xtal_stop), .pulse_o(ref_p)
  );

  synth_prog_div #(
    .DW(DW), .MIN_WIDE(MIN_WIDE), .MIN_NARROW(MIN_NARROW), .NARROW_LSB(NARROW_LSB)
  ) u_fb (
    .clk(clk), .rst(rst), .halt(halt), .tick(vco_tick), .word(div_word),
    .dbl(dbl_mode), .hi(hi_band), .pulse_o(div_p)
  );

  synth_phase_cmp u_pfd (
    .clk(clk), .rst(rst), .halt(halt), .force_low(force_low),
    .ref_p(ref_p), .div_p(div_p),
    .up_o(pump_up), .dn_o(pump_dn), .hiz_o(pump_hiz), .err_o(err)
  );

  synth_lock_mon #(.ERR_LIMIT(ERR_LIMIT), .HOLD_LEN(HOLD_LEN)) u_lock (
    .clk(clk), .rst(rst), .mode_i(ulk_mode), .err_i(err), .lock_o(lock_ok)
  );

endmodule

// File: tb/synth_pll_core_tb.sv
`timescale 1ns/1ps
module synth_pll_core_tb;
  localparam int ERRL = 6;
  localparam int HOLD = 40;
  localparam int NV   = 22;

  // {is_ref, dbl, hi, value[15:0], expected[16:0]}
  localparam logic [35:0] VEC [NV] = '{
    {1'b0, 1'b1, 1'b0, 16'd300,   17'd600},   // R1
    {1'b0, 1'b1, 1'b0, 16'd10,    17'd544},   // R4 wide doubled clamp
    {1'b0, 1'b0, 1'b1, 16'd500,   17'd500},   // R2
    {1'b0, 1'b0, 1'b1, 16'd100,   17'd272},   // R4 wide clamp
    {1'b0, 1'b0, 1'b1, 16'd272,   17'd272},   // R2 boundary
    {1'b0, 1'b0, 1'b0, 16'h0123,  17'd18},    // R3 low nibble ignored
    {1'b0, 1'b0, 1'b0, 16'h0015,  17'd4},     // R4 narrow clamp
    {1'b0, 1'b0, 1'b0, 16'hFFF0,  17'd4095},  // R3 max
    {1'b1, 1'b0, 1'b0, 16'd0,  17'd3},  {1'b1, 1'b0, 1'b0, 16'd1,  17'd3},
    {1'b1, 1'b0, 1'b0, 16'd2,  17'd3},  {1'b1, 1'b0, 1'b0, 16'd3,  17'd3},
    {1'b1, 1'b0, 1'b0, 16'd4,  17'd6},  {1'b1, 1'b0, 1'b0, 16'd5,  17'd12},
    {1'b1, 1'b0, 1'b0, 16'd6,  17'd24}, {1'b1, 1'b0, 1'b0, 16'd7,  17'd24},
    {1'b1, 1'b0, 1'b0, 16'd8,  17'd15}, {1'b1, 1'b0, 1'b0, 16'd9,  17'd15},
    {1'b1, 1'b0, 1'b0, 16'd10, 17'd15}, {1'b1, 1'b0, 1'b0, 16'd11, 17'd75},
    {1'b1, 1'b0, 1'b0, 16'd12, 17'd25}, {1'b1, 1'b0, 1'b0, 16'd13, 17'd5}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        vco_tick = 1'b0, xtal_tick = 1'b0;
  logic [15:0] div_word = 16'd300;
  logic        dbl_mode = 1'b0, hi_band = 1'b1;
  logic [3:0]  ref_sel = 4'd13;
  logic [1:0]  ulk_mode = 2'b00;
  logic        force_low = 1'b0;
  logic        pump_up, pump_dn, pump_hiz, lock_ok, xtal_stop;

  int n_tests = 0;
  int n_fail  = 0;

  always #2.5 clk = ~clk;

  synth_pll_core #(.ERR_LIMIT(ERRL), .HOLD_LEN(HOLD)) u_dut (
    .clk(clk), .rst(rst), .vco_tick(vco_tick), .xtal_tick(xtal_tick),
    .div_word(div_word), .dbl_mode(dbl_mode), .hi_band(hi_band),
    .ref_sel(ref_sel), .ulk_mode(ulk_mode), .force_low(force_low),
    .pump_up(pump_up), .pump_dn(pump_dn), .pump_hiz(pump_hiz),
    .lock_ok(lock_ok), .xtal_stop(xtal_stop)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1; step(2); rst = 1'b0; step(3);
  endtask

  task automatic vco_n(input int n);
    vco_tick = 1'b1; repeat (n) @(negedge clk); vco_tick = 1'b0;
  endtask

  task automatic xtal_n(input int n);
    xtal_tick = 1'b1; repeat (n) @(negedge clk); xtal_tick = 1'b0;
  endtask

  task automatic count_vco(output int n, input int lim);
    n = 0;
    while (pump_dn !== 1'b1 && n < lim) begin vco_n(1); step(2); n++; end
  endtask

  task automatic count_xtal(output int n, input int lim);
    n = 0;
    while (pump_up !== 1'b1 && n < lim) begin xtal_n(1); step(2); n++; end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog (all requirements): got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests + 1, n_fail);
    $finish;
  end

  initial begin
    int got;
    step(3);
    do_reset();
    // R13 reset state
    chk(pump_up == 0 && pump_dn == 0 && pump_hiz == 0 && xtal_stop == 0,
        "R13", "pump/stop outputs after reset", {pump_up, pump_dn, pump_hiz, xtal_stop}, 0);
    chk(lock_ok == 1, "R13", "lock_ok after reset", lock_ok, 1);

    // Vector table: divider ratios (R1 R2 R3 R4 R5)
    for (int i = 0; i < NV; i++) begin
      logic [35:0] e;
      string tag;
      e = VEC[i];
      if (e[35]) begin
        ref_sel = e[20:17]; dbl_mode = 1'b0; hi_band = 1'b1; div_word = 16'd300;
        do_reset();
        count_xtal(got, int'(e[16:0]) + 4);
        chk(got == int'(e[16:0]), "R5", $sformatf("ref ratio code %0d", e[20:17]),
            got, int'(e[16:0]));
      end else begin
        ref_sel = 4'd13; dbl_mode = e[34]; hi_band = e[33]; div_word = e[32:17];
        do_reset();
        count_vco(got, int'(e[16:0]) + 4);
        if (e[34]) tag = (e[32:17] < 16'd272) ? "R4" : "R1";
        else if (e[33]) tag = (e[32:17] < 16'd272) ? "R4" : "R2";
        else tag = (e[32:21] < 12'd4) ? "R4" : "R3";
        chk(got == int'(e[16:0]), tag, $sformatf("feedback ratio word %0h", e[32:17]),
            got, int'(e[16:0]));
      end
    end

    // R6: word change mid-period applies at next terminal count
    ref_sel = 4'd13; dbl_mode = 1'b0; hi_band = 1'b1; div_word = 16'd300; ulk_mode = 2'b00;
    do_reset();
    vco_n(100);
    div_word = 16'd280;
    vco_n(199); step(2);
    chk(pump_dn == 0, "R6", "dn before old period ends", pump_dn, 0);
    vco_n(1); step(2);
    chk(pump_dn == 1, "R6", "dn at old period end", pump_dn, 1);
    xtal_n(5); step(2);
    chk(pump_up == 0 && pump_dn == 0, "R7", "both clear after ref arrives",
        {pump_up, pump_dn}, 0);
    vco_n(279); step(2);
    chk(pump_dn == 0, "R6", "dn before new period ends", pump_dn, 0);
    vco_n(1); step(2);
    chk(pump_dn == 1, "R6", "dn at new period end", pump_dn, 1);

    // R7: coincident terminal counts cancel
    ref_sel = 4'd13; hi_band = 1'b0; div_word = 16'h0050;
    do_reset();
    vco_tick = 1'b1; xtal_tick = 1'b1;
    step(5);
    vco_tick = 1'b0; xtal_tick = 1'b0;
    begin
      bit seen = 1'b0;
      for (int k = 0; k < 6; k++) begin
        step(1);
        if (pump_up || pump_dn) seen = 1'b1;
      end
      chk(!seen, "R7", "coincident pulses raise no pump output", seen, 0);
    end
    xtal_n(5); step(2);
    chk(pump_up == 1, "R7", "up after next ref period", pump_up, 1);

    // R8: halt codes
    ref_sel = 4'd15; step(2);
    chk(pump_hiz == 1 && pump_up == 0 && pump_dn == 0 && xtal_stop == 0,
        "R8", "code 15 hiz/up/dn/stop", {pump_hiz, pump_up, pump_dn, xtal_stop}, 8);
    xtal_n(10); vco_n(10); step(2);
    chk(pump_up == 0 && pump_dn == 0, "R8", "ticks ignored while halted",
        {pump_up, pump_dn}, 0);
    ref_sel = 4'd14; step(2);
    chk(xtal_stop == 1 && pump_hiz == 1, "R8", "code 14 stop and hiz",
        {xtal_stop, pump_hiz}, 3);
    ref_sel = 4'd13; step(2);
    chk(pump_hiz == 0 && xtal_stop == 0, "R8", "release from halt",
        {pump_hiz, xtal_stop}, 0);
    count_xtal(got, 10);
    chk(got == 5, "R6", "full ref period after halt", got, 5);

    // R9: forced sinking
    do_reset();
    force_low = 1'b1; step(2);
    chk(pump_dn == 1 && pump_up == 0 && pump_hiz == 0, "R9", "forced low",
        {pump_dn, pump_up, pump_hiz}, 4);
    ref_sel = 4'd15; step(2);
    chk(pump_hiz == 1 && pump_dn == 0, "R9", "halt overrides force",
        {pump_hiz, pump_dn}, 2);
    ref_sel = 4'd13; force_low = 1'b0; step(3);
    chk(pump_dn == 0 && pump_up == 0, "R9", "normal after force released",
        {pump_dn, pump_up}, 0);

    // R10: monitor off
    ulk_mode = 2'b00; div_word = 16'h0040;
    do_reset();
    xtal_n(5); step(30);
    chk(pump_up == 1 && lock_ok == 1, "R10", "long error with monitor off",
        {pump_up, lock_ok}, 3);
    vco_n(4); step(2);
    chk(pump_up == 0 && pump_dn == 0, "R7", "cleared by feedback pulse",
        {pump_up, pump_dn}, 0);

    // R11: raw error
    ulk_mode = 2'b01;
    do_reset();
    xtal_n(5); step(2);
    chk(pump_up == 1 && lock_ok == 0, "R11", "raw error shown", {pump_up, lock_ok}, 2);
    vco_n(4); step(3);
    chk(lock_ok == 1, "R11", "raw error gone", lock_ok, 1);

    // R12: windowed detection
    ulk_mode = 2'b10;
    do_reset();
    xtal_n(5); vco_n(4);
    begin
      bit low = 1'b0;
      for (int k = 0; k < 20; k++) begin
        step(1);
        if (!lock_ok) low = 1'b1;
      end
      chk(!low, "R12", "short error ignored", low, 0);
    end
    do_reset();
    xtal_n(5); step(30);
    chk(lock_ok == 0, "R12", "long error unlocks", lock_ok, 0);
    vco_n(4); step(HOLD - 5);
    chk(lock_ok == 0, "R12", "unlock stretched", lock_ok, 0);
    step(12);
    chk(lock_ok == 1, "R12", "lock after stretch", lock_ok, 1);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule